// File: doc/BRIEF.md
# Sleep-Entry Cache Way Shrink Controller

This controller sits beside an N-way cache and decides, each time the package enters its deep sleep state, whether to make the cache smaller. When it shrinks, it first asks the cache to flush a group of ways and waits for the cache to report that the flush is complete. Only then does it mark those ways as disabled and acknowledge the sleep entry. If the entry does not qualify, it acknowledges straight away and leaves the ways as they are.

Two conditions must both hold for an entry to shrink the cache. The first is that the active-residency timer has not expired. This timer counts cycles in which the package is in its normal active state, and every accepted sleep entry clears it, so that entries following closely on one another keep shrinking the cache. The second is that a programmable threshold is met: the number of enabled ways must exceed the threshold, and a threshold of zero removes this condition. Ways are taken from the top of the enabled range downward, and way 0 always stays enabled. A restore input enables every way again and clears the timer.

Top module: `cache_shrink_ctrl`

## Requirements
- R1: After reset, no way is disabled, no flush is requested, no acknowledge is given, and the residency count is zero.
- R2: The residency count advances by one on each cycle in which `pkg_active_i` is high and stops at `res_limit_i`. The timer counts as expired once the count equals `res_limit_i`. Cycles with `pkg_active_i` low do not advance the count.
- R3: A sleep entry accepted while the timer is expired does not flush anything and leaves `way_dis_o` unchanged.
- R4: Every accepted sleep entry clears the residency count, whether or not that entry shrinks the cache.
- R5: Let E be the number of enabled ways. An entry shrinks only if `thresh_i` is 0 or E is greater than `thresh_i`.
- R6: When an entry shrinks, `flush_req_o` stays high until `flush_done_i` is seen. During that time `flush_ways_o` is stable and has bit i set for the `g` highest-numbered enabled ways, where g = min(`shrink_step_i`, E-1).
- R7: `way_dis_o` changes only in the cycle after the controller sees `flush_done_i` during a flush, or after a restore. In every case `sleep_ack_o` is high for exactly one cycle: one cycle after the flush completes, or one cycle after the entry is accepted when there is no flush.
- R8: Way 0 is never disabled. The number of ways disabled in one step is limited so that at least one way stays enabled. When only one way is enabled, an entry does not flush.
- R9: When `shrink_step_i` is 0, an entry does not flush and only acknowledges.
- R10: A restore seen while the controller is idle clears `way_dis_o` and the residency count, and it takes priority over a sleep request in the same cycle. A restore seen during a flush or an acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkg_active_i | input | 1 | Package is in the normal active state |
| sleep_req_i | input | 1 | Deep-sleep entry request, held high until acknowledged |
| sleep_ack_o | output | 1 | Acknowledge pulse for a sleep entry |
| shrink_step_i | input | CW | Number of ways to remove per qualifying entry |
| thresh_i | input | CW | Shrink threshold on the enabled-way count (0 means ignored) |
| res_limit_i | input | TMR_W | Residency limit, in active cycles |
| restore_i | input | 1 | Re-enable all ways and clear the residency count |
| flush_req_o | output | 1 | Flush request to the cache |
| flush_ways_o | output | NUM_WAYS | Ways selected for flushing |
| flush_done_i | input | 1 | Cache reports that the flush is complete |
| way_dis_o | output | NUM_WAYS | Disabled-way mask |

## Verification
The bench builds the controller with eight ways and an 8-bit residency timer, using small residency limits. With these values the timer can be driven exactly to its limit, and a few entries are enough to shrink the cache down to its last way. The threshold can be set so that it stops shrinking partway down. Flush-done latencies of zero and several cycles are mixed, and a restore is sent in the middle of a flush.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_ACK   = 2'd2
  } csc_state_e;
endpackage

// File: rtl/csc_res_timer.sv
module csc_res_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             active_i,
  input  logic [TMR_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (active_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !active_i) |=> (!$stable(limit_i) || $stable(expired_o)));
endmodule

// File: rtl/csc_way_sel.sv
module csc_way_sel #(
  parameter int NUM_WAYS = 8,
  parameter int CW       = $clog2(NUM_WAYS + 1)
) (
  input  logic [CW-1:0]       dis_cnt_i,
  input  logic [CW-1:0]       pend_cnt_i,
  input  logic [CW-1:0]       step_i,
  output logic [CW-1:0]       enabled_o,
  output logic [CW-1:0]       grant_o,
  output logic [NUM_WAYS-1:0] way_dis_o,
  output logic [NUM_WAYS-1:0] sel_ways_o
);
  localparam int XW = CW + 1;
  localparam logic [XW-1:0] NW = XW'(NUM_WAYS);

  logic [CW-1:0] avail;

  assign enabled_o = CW'(NUM_WAYS) - dis_cnt_i;
  assign avail     = (enabled_o == '0) ? '0 : enabled_o - 1'b1;
  assign grant_o   = (step_i < avail) ? step_i : avail;

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_way
    logic [XW-1:0] s_dis, s_pend;
    assign s_dis         = XW'(i) + XW'(dis_cnt_i);
    assign s_pend        = XW'(i) + XW'(pend_cnt_i);
    assign way_dis_o[i]  = (s_dis >= NW);
    assign sel_ways_o[i] = (s_pend >= NW) && (s_dis < NW);
  end
endmodule

// File: rtl/cache_shrink_ctrl.sv
module cache_shrink_ctrl
  import csc_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int TMR_W    = 16,
  localparam int CW      = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pkg_active_i,
  input  logic                sleep_req_i,
  output logic                sleep_ack_o,
  input  logic [CW-1:0]       shrink_step_i,
  input  logic [CW-1:0]       thresh_i,
  input  logic [TMR_W-1:0]    res_limit_i,
  input  logic                restore_i,
  output logic                flush_req_o,
  output logic [NUM_WAYS-1:0] flush_ways_o,
  input  logic                flush_done_i,
  output logic [NUM_WAYS-1:0] way_dis_o
);
  csc_state_e          state_q, state_d;
  logic [CW-1:0]       dis_q, dis_d, pend_q, pend_d;
  logic [CW-1:0]       enabled, grant;
  logic [NUM_WAYS-1:0] sel_ways;
  logic                expired, tmr_clr, idle, thresh_hit, shrink_ok;

  assign idle = (state_q == ST_IDLE);
  // accepted entry or restore clears residency
  assign tmr_clr = idle && (restore_i || sleep_req_i);

  csc_res_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .active_i (pkg_active_i),
    .limit_i  (res_limit_i),
    .expired_o(expired)
  );

  csc_way_sel #(.NUM_WAYS(NUM_WAYS), .CW(CW)) u_sel (
    .dis_cnt_i (dis_q),
    .pend_cnt_i(pend_q),
    .step_i    (shrink_step_i),
    .enabled_o (enabled),
    .grant_o   (grant),
    .way_dis_o (way_dis_o),
    .sel_ways_o(sel_ways)
  );

  assign thresh_hit = (thresh_i == '0) || (enabled > thresh_i);
  assign shrink_ok  = !expired && thresh_hit && (grant != '0);

  always_comb begin
    state_d = state_q;
    dis_d   = dis_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (restore_i) begin
          dis_d  = '0;
          pend_d = '0;
        end else if (sleep_req_i) begin
          pend_d  = shrink_ok ? dis_q + grant : dis_q;
          state_d = shrink_ok ? ST_FLUSH : ST_ACK;
        end
      end
      ST_FLUSH: begin
        if (flush_done_i) begin
          dis_d   = pend_q;
          state_d = ST_ACK;
        end
      end
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dis_q   <= '0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      dis_q   <= dis_d;
      pend_q  <= pend_d;
    end
  end

  assign flush_req_o  = (state_q == ST_FLUSH);
  assign flush_ways_o = flush_req_o ? sel_ways : '0;
  assign sleep_ack_o  = (state_q == ST_ACK);

  // R8
  last_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !way_dis_o[0]);

  // R6
  flush_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> (flush_ways_o != '0) && ((flush_ways_o & way_dis_o) == '0));

  // R6
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o && !flush_done_i) |=> (flush_req_o && $stable(flush_ways_o)));

  // R7
  mask_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (way_dis_o != $past(way_dis_o)) |->
      ($past(flush_req_o && flush_done_i) || $past(restore_i)));

  // R7
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_o |=> !sleep_ack_o);

  // R10
  restore_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !flush_req_o && !sleep_ack_o) |=> (way_dis_o == '0));
endmodule

// File: tb/tb_cache_shrink_ctrl.sv
module tb_cache_shrink_ctrl;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);
  localparam int TW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pkg_active_i = 0, sleep_req_i = 0, restore_i = 0, flush_done_i = 0;
  logic [CW-1:0] shrink_step_i = '0, thresh_i = '0;
  logic [TW-1:0] res_limit_i = '0;
  logic sleep_ack_o, flush_req_o;
  logic [N-1:0] flush_ways_o, way_dis_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cache_shrink_ctrl #(.NUM_WAYS(N), .TMR_W(TW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pkg_active_i(pkg_active_i),
    .sleep_req_i(sleep_req_i), .sleep_ack_o(sleep_ack_o),
    .shrink_step_i(shrink_step_i), .thresh_i(thresh_i),
    .res_limit_i(res_limit_i), .restore_i(restore_i),
    .flush_req_o(flush_req_o), .flush_ways_o(flush_ways_o),
    .flush_done_i(flush_done_i), .way_dis_o(way_dis_o)
  );

  // behavioural reference
  int m_st = 0, m_cnt = 0, m_dis = 0, m_pend = 0;

  function automatic logic [N-1:0] top_mask(int k);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) if (i >= N - k) m[i] = 1'b1;
    return m;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_dis = 0; m_pend = 0;
    end else begin
      bit exp_now, clr;
      int en, g;
      exp_now = (m_cnt >= int'(res_limit_i));
      clr = (m_st == 0) && (restore_i || sleep_req_i);
      case (m_st)
        0: if (restore_i) m_dis = 0;
           else if (sleep_req_i) begin
             en = N - m_dis;
             g  = (int'(shrink_step_i) < en - 1) ? int'(shrink_step_i) : en - 1;
             if (!exp_now && (thresh_i == 0 || en > int'(thresh_i)) && g > 0) begin
               m_pend = m_dis + g; m_st = 1;
             end else m_st = 2;
           end
        1: if (flush_done_i) begin m_dis = m_pend; m_st = 2; end
        default: m_st = 0;
      endcase
      if (clr) m_cnt = 0;
      else if (pkg_active_i && m_cnt < int'(res_limit_i)) m_cnt++;
    end
  end

  task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // cycle compare against reference
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk("R6 flush_req", N'(flush_req_o), N'(m_st == 1));
    chk("R6 flush_ways", flush_ways_o,
        (m_st == 1) ? (top_mask(m_pend) & ~top_mask(m_dis)) : '0);
    chk("R7 way_dis", way_dis_o, top_mask(m_dis));
    chk("R7 ack", N'(sleep_ack_o), N'(m_st == 2));
  end

  task automatic enter_sleep(int dly, bit rst_mid = 0);
    int d = dly;
    bit fired = 0;
    @(negedge clk_i);
    sleep_req_i = 1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      restore_i = 0;
      if (flush_req_o) begin
        if (rst_mid && !fired) begin restore_i = 1; fired = 1; end
        if (d == 0) flush_done_i = 1; else d--;
      end else flush_done_i = 0;
      if (sleep_ack_o) begin sleep_req_i = 0; flush_done_i = 0; break; end
    end
    @(negedge clk_i);
  endtask

  task automatic run_active(int n);
    @(negedge clk_i);
    pkg_active_i = 1;
    repeat (n) @(negedge clk_i);
    pkg_active_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog got=hung exp=finish");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 way_dis", way_dis_o, '0);
    chk("R1 flush_req", N'(flush_req_o), '0);
    chk("R1 ack", N'(sleep_ack_o), '0);
    rst_ni = 1;
    shrink_step_i = 2; thresh_i = 0; res_limit_i = 5;
    @(negedge clk_i);
    enter_sleep(0);
    chk("R6 step2", way_dis_o, 8'hC0);
    run_active(4);
    enter_sleep(3);
    chk("R2 below limit shrinks", way_dis_o, 8'hF0);
    run_active(5);
    enter_sleep(0);
    chk("R3 expired no shrink", way_dis_o, 8'hF0);
    enter_sleep(1);
    chk("R4 cleared timer shrinks", way_dis_o, 8'hFC);
    enter_sleep(0);
    chk("R8 clip to one way", way_dis_o, 8'hFE);
    enter_sleep(0);
    chk("R8 last way kept", way_dis_o, 8'hFE);
    run_active(6);
    @(negedge clk_i); restore_i = 1;
    @(negedge clk_i); restore_i = 0;
    @(negedge clk_i);
    chk("R10 restore clears", way_dis_o, '0);
    enter_sleep(0);
    chk("R10 timer cleared", way_dis_o, 8'hC0);
    // restore wins over request in same cycle
    @(negedge clk_i); restore_i = 1; sleep_req_i = 1;
    @(negedge clk_i); restore_i = 0; sleep_req_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    chk("R10 restore priority", way_dis_o, '0);
    thresh_i = 6; shrink_step_i = 1;
    enter_sleep(2);
    chk("R5 8>6", way_dis_o, 8'h80);
    enter_sleep(0);
    chk("R5 7>6", way_dis_o, 8'hC0);
    enter_sleep(0);
    chk("R5 6 not >6", way_dis_o, 8'hC0);
    thresh_i = 0; shrink_step_i = 0;
    enter_sleep(0);
    chk("R9 zero step", way_dis_o, 8'hC0);
    shrink_step_i = 3;
    enter_sleep(2, 1);
    chk("R10 restore in flush ignored", way_dis_o, 8'hF8);
    @(negedge clk_i);
    repeat (20) @(negedge clk_i);
    enter_sleep(1);
    chk("R2 inactive not counted", way_dis_o, 8'hFF & 8'hFE);
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule